// File: doc/BRIEF.md
# DRAM Refresh Credit Scheduler

This block decides when a DDR SDRAM controller must send refresh commands. A free-running interval timer adds one refresh credit every average refresh period, 7.8 µs by default: 1040 cycles of a 7.5 ns clock, which gives 8K refreshes per 64 ms. Credits pile up in a bounded debt counter. The controller can therefore put refreshes off while traffic is heavy and later drain them back-to-back.

The command arbiter reports when every bank is idle. A refresh may be issued only in that state. The scheduler raises its request whenever it owes at least one refresh, the arbiter is idle and no refresh is still in progress. The request turns urgent once the debt reaches its ceiling. Each accepted grant retires one credit. It also raises a hold-off output that keeps every other command away for the refresh cycle time, rounded up to whole clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: The interval timer starts from zero when reset is released and wraps every INTERVAL_CYC cycles. Each wrap adds one credit whether or not credits are pending, so the first request after reset, with the arbiter idle, appears INTERVAL_CYC cycles after release.
- R2: `ref_req_o` is high exactly when the debt is nonzero, `arb_idle_i` is high and `cmd_block_o` is low.
- R3: `ref_urgent_o` is high exactly when the debt equals MAX_DEBT (default 8).
- R4: A grant is accepted only in a cycle where `ref_gnt_i` and `ref_req_o` are both high, and each accepted grant lowers the debt by one. A grant that arrives while `ref_req_o` is low changes nothing.
- R5: After an accepted grant, `cmd_block_o` is high for exactly ceil(TRFC_PS / TCK_PS) consecutive cycles, starting in the next cycle.
- R6: The debt never goes above MAX_DEBT. A credit that arrives at MAX_DEBT without an accepted grant in the same cycle sets `credit_ovf_o`, which stays high until reset. A credit and an accepted grant in the same cycle at MAX_DEBT leave the debt at MAX_DEBT and do not set the flag.
- R7: Reset clears the debt, the overflow flag and the hold-off, and restarts the interval timer.
- R8: When the arbiter stays idle and grants every request, a postponed debt is drained back-to-back, with one accepted grant every TRFC cycles plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_idle_i | input | 1 | Arbiter reports that all banks are idle |
| ref_gnt_i | input | 1 | Arbiter issues the refresh in this cycle |
| ref_req_o | output | 1 | Refresh wanted now |
| ref_urgent_o | output | 1 | Debt at its ceiling; refresh may not be put off any longer |
| cmd_block_o | output | 1 | Hold off all other commands (refresh cycle in progress) |
| credit_ovf_o | output | 1 | Sticky flag: a credit was lost at the ceiling |

## Verification
The bound checker watches, on every cycle, the relations that hold locally. These are: a request only while the arbiter is idle and no hold-off is running; an urgent, idle and unblocked state always requesting; a hold-off right after each accepted grant, lasting exactly the refresh cycle count; and the overflow flag staying set. The bench scenarios cover the behaviours that depend on history. These are the spacing of credits from reset, debt accumulation up to the ceiling, loss of a credit at the ceiling against the tie of a credit and a grant, ignored grants, and the timing of a back-to-back drain.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

   // Default timing: 7.8 us average interval at a 7.5 ns clock.
   localparam int unsigned DEF_INTERVAL_CYC = 1040;
   localparam int unsigned DEF_MAX_DEBT     = 8;
   localparam int unsigned DEF_TRFC_PS      = 75000;
   localparam int unsigned DEF_TCK_PS       = 7500;

   // Integer division rounded up; used to turn a time into cycles.
   function automatic int unsigned ceil_div(input int unsigned num,
                                            input int unsigned den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/ref_interval_tmr.sv
module ref_interval_tmr #(
   parameter int unsigned INTERVAL_CYC = 1040
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int unsigned CW = $clog2(INTERVAL_CYC);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

   logic [CW-1:0] cnt_q;

   generate
      if ((INTERVAL_CYC & (INTERVAL_CYC - 1)) == 0) begin : g_pow2
         // Power of two: natural wrap, no compare in the feedback path.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = &cnt_q;
      end else begin : g_modn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
   parameter int unsigned MAX_DEBT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic credit_i,
   input  logic take_i,
   output logic nz_o,
   output logic full_o,
   output logic ovf_o
);
   localparam int unsigned DW = $clog2(MAX_DEBT + 1);
   localparam logic [DW-1:0] TOP = DW'(MAX_DEBT);

   logic [DW-1:0] debt_q;
   logic          ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         unique case ({credit_i, take_i})
            2'b10: begin
               if (debt_q == TOP) ovf_q  <= 1'b1;
               else               debt_q <= debt_q + 1'b1;
            end
            2'b01:   debt_q <= debt_q - 1'b1;
            default: debt_q <= debt_q;
         endcase
      end
   end

   assign nz_o   = (debt_q != '0);
   assign full_o = (debt_q == TOP);
   assign ovf_o  = ovf_q;
endmodule

// File: rtl/ref_hold_tmr.sv
module ref_hold_tmr #(
   parameter int unsigned HOLD_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   generate
      if (HOLD_CYC == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start_i;
         end
         assign busy_o = busy_q;
      end else begin : g_count
         localparam int unsigned HW = $clog2(HOLD_CYC + 1);
         localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC);
         logic [HW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             left_q <= '0;
            else if (start_i)       left_q <= LOAD;
            else if (left_q != '0)  left_q <= left_q - 1'b1;
         end
         assign busy_o = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
   parameter int unsigned INTERVAL_CYC = refsch_pkg::DEF_INTERVAL_CYC,
   parameter int unsigned MAX_DEBT     = refsch_pkg::DEF_MAX_DEBT,
   parameter int unsigned TRFC_PS      = refsch_pkg::DEF_TRFC_PS,
   parameter int unsigned TCK_PS       = refsch_pkg::DEF_TCK_PS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arb_idle_i,
   input  logic ref_gnt_i,
   output logic ref_req_o,
   output logic ref_urgent_o,
   output logic cmd_block_o,
   output logic credit_ovf_o
);
   localparam int unsigned TRFC_CYC = refsch_pkg::ceil_div(TRFC_PS, TCK_PS);

   generate
      if (INTERVAL_CYC < 2) begin : g_bad_interval
         $error("refresh_sched: INTERVAL_CYC must be at least 2");
      end
      if (MAX_DEBT < 1) begin : g_bad_debt
         $error("refresh_sched: MAX_DEBT must be at least 1");
      end
      if (TCK_PS == 0 || TRFC_CYC < 1) begin : g_bad_trfc
         $error("refresh_sched: refresh cycle must span at least one clock");
      end
   endgenerate

   logic tick;
   logic debt_nz;
   logic accept;

   ref_interval_tmr #(.INTERVAL_CYC(INTERVAL_CYC)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   ref_debt_ctr #(.MAX_DEBT(MAX_DEBT)) u_debt (
      .clk      (clk),
      .rst_n    (rst_n),
      .credit_i (tick),
      .take_i   (accept),
      .nz_o     (debt_nz),
      .full_o   (ref_urgent_o),
      .ovf_o    (credit_ovf_o)
   );

   ref_hold_tmr #(.HOLD_CYC(TRFC_CYC)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .busy_o  (cmd_block_o)
   );

   assign ref_req_o = debt_nz & arb_idle_i & ~cmd_block_o;
   assign accept    = ref_gnt_i & ref_req_o;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
   parameter int unsigned HOLD_CYC = 10
) (
   input logic clk,
   input logic rst_n,
   input logic arb_idle_i,
   input logic ref_gnt_i,
   input logic ref_req_o,
   input logic ref_urgent_o,
   input logic cmd_block_o,
   input logic credit_ovf_o
);
   localparam logic [15:0] HOLD16 = 16'(HOLD_CYC);

   logic [15:0] blk_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           blk_run <= '0;
      else if (cmd_block_o) blk_run <= blk_run + 16'd1;
      else                  blk_run <= '0;
   end

   a_r2_req_only_idle_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req_o |-> (arb_idle_i && !cmd_block_o));

   a_r3_urgent_requests: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_urgent_o && arb_idle_i && !cmd_block_o) |-> ref_req_o);

   a_r5_block_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_gnt_i && ref_req_o) |=> cmd_block_o);

   a_r5_block_not_too_long: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_block_o |-> (blk_run < HOLD16));

   a_r5_block_full_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_block_o) |-> (blk_run == HOLD16));

   a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      credit_ovf_o |=> credit_ovf_o);
endmodule

bind refresh_sched refresh_sched_chk #(.HOLD_CYC(TRFC_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arb_idle_i   (arb_idle_i),
   .ref_gnt_i    (ref_gnt_i),
   .ref_req_o    (ref_req_o),
   .ref_urgent_o (ref_urgent_o),
   .cmd_block_o  (cmd_block_o),
   .credit_ovf_o (credit_ovf_o)
);

// File: tb/refresh_sched_tb_top.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;
   localparam int INTERVAL = 40;
   localparam int MAXD     = 8;
   localparam int TRFC_PS  = 75000;
   localparam int TCK_PS   = 4000;
   localparam int HOLD     = (TRFC_PS + TCK_PS - 1) / TCK_PS; // 19

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arb_idle_i = 1'b0;
   logic ref_gnt_i = 1'b0;
   logic ref_req_o, ref_urgent_o, cmd_block_o, credit_ovf_o;

   always #2 clk = ~clk;

   refresh_sched #(
      .INTERVAL_CYC(INTERVAL), .MAX_DEBT(MAXD),
      .TRFC_PS(TRFC_PS), .TCK_PS(TCK_PS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .arb_idle_i(arb_idle_i), .ref_gnt_i(ref_gnt_i),
      .ref_req_o(ref_req_o), .ref_urgent_o(ref_urgent_o),
      .cmd_block_o(cmd_block_o), .credit_ovf_o(credit_ovf_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // Bench model of the requirements
   int m_cnt = 0, m_debt = 0, m_hold = 0, step_no = 0;
   bit m_err = 1'b0;
   int gnt_steps[$];
   logic [3:0] exp_q[$];   // {req, urgent, block, ovf}

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Called at a falling edge; drives inputs, predicts outputs, advances model.
   // mode: 0 no grant, 1 grant whenever a request is expected, 2 grant always.
   task automatic step(input bit idle, input int mode);
      bit ereq, acc, tick;
      arb_idle_i = idle;
      ereq = (m_debt != 0) && idle && (m_hold == 0);
      ref_gnt_i = (mode == 1) ? ereq : (mode == 2);
      exp_q.push_back({ereq, m_debt == MAXD, m_hold != 0, m_err});
      acc  = ref_gnt_i && ereq;
      tick = (m_cnt == INTERVAL - 1);
      if (acc) gnt_steps.push_back(step_no);
      if (tick && !acc) begin
         if (m_debt == MAXD) m_err = 1'b1; else m_debt++;
      end else if (acc && !tick) m_debt--;
      if (acc) m_hold = HOLD; else if (m_hold != 0) m_hold--;
      m_cnt = tick ? 0 : m_cnt + 1;
      step_no++;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; arb_idle_i = 1'b0; ref_gnt_i = 1'b0;
      repeat (3) @(negedge clk);
      // R7: state cleared while reset is held
      check({ref_req_o, ref_urgent_o, cmd_block_o, credit_ovf_o} == 4'b0,
            "R7 outputs in reset", {ref_req_o, ref_urgent_o, cmd_block_o, credit_ovf_o}, 0);
      m_cnt = 0; m_debt = 0; m_hold = 0; m_err = 1'b0; step_no = 0;
      gnt_steps.delete();
      rst_n = 1'b1;
   endtask

   // Monitor: compares every predicted item against the ports.
   initial begin
      logic [3:0] e;
      forever begin
         @(negedge clk);
         #1;
         while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(ref_req_o == e[3],    "R2 ref_req_o",    ref_req_o,    e[3]);
            check(ref_urgent_o == e[2], "R3 ref_urgent_o", ref_urgent_o, e[2]);
            check(cmd_block_o == e[1],  "R5 cmd_block_o",  cmd_block_o,  e[1]);
            check(credit_ovf_o == e[0], "R6 credit_ovf_o", credit_ovf_o, e[0]);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int first_req;
      @(negedge clk);
      do_reset();

      // R1: first request exactly INTERVAL cycles after release
      first_req = -1;
      for (int i = 0; i < INTERVAL + 2; i++) begin
         if (first_req < 0 && ref_req_o) first_req = step_no;
         step(1'b1, 0);
      end
      check(first_req == INTERVAL, "R1 first request step", first_req, INTERVAL);

      // R4/R5: one grant retires the credit and starts the hold-off
      for (int i = 0; i < HOLD + 5; i++) step(1'b1, 1);
      check(gnt_steps.size() == 1, "R4 single grant accepted", gnt_steps.size(), 1);
      check(ref_req_o == 1'b0, "R4 debt cleared after grant", ref_req_o, 0);

      // R4: grants while busy are ignored; debt keeps building to the ceiling
      for (int i = 0; i < 10; i++) step(1'b0, 2);
      while (m_debt < MAXD) step(1'b0, 2);
      step(1'b0, 0);
      check(ref_urgent_o == 1'b1, "R4 ignored grants kept debt, R3 urgent", ref_urgent_o, 1);

      // R6: one more credit at the ceiling is lost and flagged
      for (int i = 0; i < INTERVAL; i++) step(1'b0, 0);
      check(credit_ovf_o == 1'b1, "R6 overflow flagged", credit_ovf_o, 1);

      // R8: back-to-back drain
      gnt_steps.delete();
      for (int i = 0; i < MAXD * (HOLD + 1) + 2; i++) step(1'b1, 1);
      check(gnt_steps.size() >= MAXD, "R8 drain grant count", gnt_steps.size(), MAXD);
      for (int k = 1; k < MAXD && k < gnt_steps.size(); k++)
         check(gnt_steps[k] - gnt_steps[k-1] == HOLD + 1, "R8 grant spacing",
               gnt_steps[k] - gnt_steps[k-1], HOLD + 1);

      // R7: reset mid-run clears flag and debt
      do_reset();
      step(1'b1, 1);
      check(credit_ovf_o == 1'b0 && ref_req_o == 1'b0, "R7 cleared after reset",
            {credit_ovf_o, ref_req_o}, 0);

      // R6: credit and grant in the same cycle at the ceiling
      while (!(m_debt == MAXD && m_cnt == INTERVAL - 1)) step(1'b0, 0);
      step(1'b1, 2);
      for (int i = 0; i < 4; i++) step(1'b0, 0);
      check(credit_ovf_o == 1'b0, "R6 tie leaves flag clear", credit_ovf_o, 0);
      check(ref_urgent_o == 1'b1, "R6 tie keeps debt at ceiling", ref_urgent_o, 1);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule